// File: doc/BRIEF.md
# Memory Barrier Sequencer

This block executes a full memory barrier in a simple in-order core. It sits beside the dispatch stage and the load/store path. When a barrier instruction is accepted, the block raises a dispatch stall that holds back every younger instruction. While the stall is up, it keeps two outstanding-operation counts. One counts older memory operations whose cache or bus activity has not finished. The other counts older touch (prefetch) operations whose address translation is still pending. It also waits for a signal saying that every older instruction is past the point where it could fault.

When broadcast is enabled, the block then requests a bus broadcast of the barrier and waits for a successful acknowledge. An unsuccessful response repeats the request. The barrier finishes with a one-cycle completion pulse. A barrier encoded with its record bit set is still carried out, and it also produces a one-cycle malformed-encoding flag, so the core can treat condition field 0 as undefined.

No store issued after the barrier can gather with one issued before it. This holds because nothing younger dispatches until every older store has completed.

Top module: `membar_ctrl`

## Requirements
- R1: After a barrier is accepted (`disp_valid` high with `disp_op` equal to the barrier code, default 37, while the block is idle), `disp_stall` is high from the next cycle. It stays high in every cycle until the completion cycle, including while `older_safe` is low.
- R2: The barrier does not complete while any older memory operation is outstanding. It completes in the cycle right after the clock edge that retires the last one, so no younger store can merge with an older one.
- R3: An older touch operation holds the barrier only until its `touch_xlat_done` pulse, and not for any bus completion.
- R4: With `bcast_en` high, once draining is finished `bcast_req` is held high. The barrier completes only in the cycle after a clock edge at which `bcast_ack` and `bcast_ok` are both high.
- R5: A `bcast_ack` with `bcast_ok` low leaves `bcast_req` high in the next cycle, which is a repeated request.
- R6: A barrier accepted with both counts at zero, `older_safe` high and `bcast_en` low raises `bar_done` in the very next cycle.
- R7: `bar_done` is a single-cycle pulse. `disp_stall` is low in the cycle after it.
- R8: A barrier accepted with `disp_rc` high raises `bad_form` for exactly one cycle, the cycle after acceptance, and is otherwise executed normally.
- R9: A dispatch with any other opcode causes no stall and no completion.
- R10: After reset, `disp_stall`, `bar_done`, `bcast_req` and `bad_form` are low and both counts are zero.
- R11: An issue and a completion of the same kind in one cycle leave that count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | An instruction is presented at dispatch |
| disp_op | input | OP_W | Opcode of the presented instruction |
| disp_rc | input | 1 | Record bit of the presented instruction |
| mem_issue | input | 1 | An older load/store starts cache or bus activity |
| mem_done | input | 1 | A load/store finishes all its activity |
| touch_issue | input | 1 | A touch operation is issued |
| touch_xlat_done | input | 1 | A touch operation finishes address translation |
| older_safe | input | 1 | All older instructions are past any fault point |
| bcast_en | input | 1 | Configuration: barrier needs a bus broadcast |
| bcast_ack | input | 1 | Bus answers the broadcast request |
| bcast_ok | input | 1 | Qualifies `bcast_ack` as successful |
| bcast_req | output | 1 | Broadcast request to the bus |
| disp_stall | output | 1 | Hold younger instructions at dispatch |
| bar_done | output | 1 | Barrier completion pulse |
| bad_form | output | 1 | Barrier had its record bit set |

## Verification
The hardest state to reach from the ports is a drain where an issue and a completion of the same kind land in the same cycle while a barrier is waiting. That cycle must neither release the barrier early nor lose an operation. The stimulus builds up several outstanding memory operations, dispatches the barrier, retires all but one of them, then drives one issue and one completion together before retiring the last. A second hard case is a failed broadcast answer. Stalling on `older_safe` with empty counts separates the fault-point wait from the counters.

// File: rtl/membar_pkg.sv
// Shared types for the memory barrier sequencer.
package membar_pkg;
    // Sequencer states
    typedef enum logic [1:0] {
        BS_IDLE  = 2'd0,
        BS_DRAIN = 2'd1,
        BS_BCAST = 2'd2,
        BS_DONE  = 2'd3
    } bar_state_t;

    // Slot numbers of the outstanding-operation trackers
    localparam int TRK_MEM   = 0;
    localparam int TRK_TOUCH = 1;
    localparam int TRK_NUM   = 2;
endpackage

// File: rtl/membar_decode.sv
// Dispatch decode for the barrier instruction.
// Recognises the barrier opcode, accepts it only when the sequencer can take
// it, and flags a barrier whose record bit is set.
// Assumes the dispatch stage holds an instruction while disp_stall is high.
module membar_decode #(
    parameter int          OP_W   = 6,
    parameter logic [OP_W-1:0] BAR_OP = OP_W'(37)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            disp_valid,
    input  logic [OP_W-1:0] disp_op,
    input  logic            disp_rc,
    input  logic            can_accept,
    output logic            bar_start,
    output logic            bad_form
);
    logic bad_q;

    // Accept a barrier only when the sequencer is idle
    always_comb begin
        bar_start = disp_valid && (disp_op == BAR_OP) && can_accept;
    end

    // Register the malformed-encoding flag as a one-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_q <= 1'b0;
        end else begin
            bad_q <= bar_start && disp_rc;
        end
    end

    assign bad_form = bad_q;
endmodule

// File: rtl/op_tracker.sv
// Outstanding-operation counter.
// Counts up on an issue and down on a completion. Both in one cycle leave it
// unchanged. It saturates at both ends, so a stray completion cannot wrap it.
// cnt_clear_next says whether the count after the coming edge is zero.
module op_tracker #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_clear_next
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Next count from this cycle's issue and completion
    always_comb begin
        cnt_d = cnt_q;
        unique case ({inc, dec})
            2'b10:   if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
            2'b01:   if (cnt_q != '0)      cnt_d = cnt_q - 1'b1;
            default: cnt_d = cnt_q;
        endcase
    end

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt            = cnt_q;
    assign cnt_clear_next = (cnt_d == '0);
endmodule

// File: rtl/membar_seq.sv
// Barrier sequencer state machine.
// IDLE -> DRAIN -> (BCAST if enabled) -> DONE -> IDLE. DRAIN and BCAST are
// skipped when their conditions already hold. DONE lasts one cycle.
// Assumes drained reflects the counts after the coming edge.
module membar_seq
    import membar_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       drained,
    input  logic       older_safe,
    input  logic       bcast_en,
    input  logic       bcast_ack,
    input  logic       bcast_ok,
    output bar_state_t state,
    output logic       can_accept,
    output logic       bcast_req,
    output logic       stall,
    output logic       done
);
    bar_state_t state_q;
    bar_state_t state_d;
    bar_state_t after_drain;
    logic       quiet;

    // Where the barrier goes once older work is quiet
    always_comb begin
        quiet       = drained && older_safe;
        after_drain = bcast_en ? BS_BCAST : BS_DONE;
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BS_IDLE:  if (start) state_d = quiet ? after_drain : BS_DRAIN;
            BS_DRAIN: if (quiet) state_d = after_drain;
            BS_BCAST: if (bcast_ack && bcast_ok) state_d = BS_DONE;
            BS_DONE:  state_d = BS_IDLE;
            default:  state_d = BS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from the current state
    always_comb begin
        can_accept = (state_q == BS_IDLE);
        stall      = (state_q != BS_IDLE);
        bcast_req  = (state_q == BS_BCAST);
        done       = (state_q == BS_DONE);
    end

    assign state = state_q;
endmodule

// File: rtl/membar_ctrl.sv
// Memory barrier controller top.
// Ties the dispatch decode, one tracker per kind of older operation, and the
// sequencer together. Memory operations count until they fully finish. Touch
// operations count only until their translation finishes.
// Assumes older operations report issue and completion at most once per cycle
// each, and no more than 2**CNT_W-1 of a kind are outstanding.
module membar_ctrl
    import membar_pkg::*;
#(
    parameter int              OP_W   = 6,
    parameter logic [OP_W-1:0] BAR_OP = OP_W'(37),
    parameter int              CNT_W  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            disp_valid,
    input  logic [OP_W-1:0] disp_op,
    input  logic            disp_rc,
    input  logic            mem_issue,
    input  logic            mem_done,
    input  logic            touch_issue,
    input  logic            touch_xlat_done,
    input  logic            older_safe,
    input  logic            bcast_en,
    input  logic            bcast_ack,
    input  logic            bcast_ok,
    output logic            bcast_req,
    output logic            disp_stall,
    output logic            bar_done,
    output logic            bad_form
);
    logic [TRK_NUM-1:0] trk_inc;
    logic [TRK_NUM-1:0] trk_dec;
    logic [TRK_NUM-1:0] trk_clear;
    logic [CNT_W-1:0]   trk_cnt [TRK_NUM];
    logic [CNT_W-1:0]   mem_cnt;
    logic [CNT_W-1:0]   touch_cnt;
    logic               all_clear;
    logic               bar_start;
    logic               can_accept;
    bar_state_t         seq_state;

    // Route issue and completion strobes to their trackers
    always_comb begin
        trk_inc            = '0;
        trk_dec            = '0;
        trk_inc[TRK_MEM]   = mem_issue;
        trk_dec[TRK_MEM]   = mem_done;
        trk_inc[TRK_TOUCH] = touch_issue;
        trk_dec[TRK_TOUCH] = touch_xlat_done;
    end

    for (genvar g = 0; g < TRK_NUM; g++) begin : g_trk
        op_tracker #(.CNT_W(CNT_W)) u_trk (
            .clk            (clk),
            .rst_n          (rst_n),
            .inc            (trk_inc[g]),
            .dec            (trk_dec[g]),
            .cnt            (trk_cnt[g]),
            .cnt_clear_next (trk_clear[g])
        );
    end

    // Older work is drained when every tracker is empty after this edge
    always_comb begin
        all_clear = &trk_clear;
        mem_cnt   = trk_cnt[TRK_MEM];
        touch_cnt = trk_cnt[TRK_TOUCH];
    end

    membar_decode #(.OP_W(OP_W), .BAR_OP(BAR_OP)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .disp_valid (disp_valid),
        .disp_op    (disp_op),
        .disp_rc    (disp_rc),
        .can_accept (can_accept),
        .bar_start  (bar_start),
        .bad_form   (bad_form)
    );

    membar_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (bar_start),
        .drained    (all_clear),
        .older_safe (older_safe),
        .bcast_en   (bcast_en),
        .bcast_ack  (bcast_ack),
        .bcast_ok   (bcast_ok),
        .state      (seq_state),
        .can_accept (can_accept),
        .bcast_req  (bcast_req),
        .stall      (disp_stall),
        .done       (bar_done)
    );
endmodule

// File: rtl/membar_ctrl_chk.sv
// Property checker for membar_ctrl, attached with bind.
module membar_ctrl_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_issue,
    input logic             mem_done,
    input logic             older_safe,
    input logic             bcast_ack,
    input logic             bcast_ok,
    input logic             bcast_req,
    input logic             disp_stall,
    input logic             bar_done,
    input logic             bad_form,
    input logic [CNT_W-1:0] mem_cnt,
    input logic [CNT_W-1:0] touch_cnt
);
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bar_done |=> !bar_done);

    assert_release_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bar_done |=> !disp_stall);

    assert_drained_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bar_done |-> (mem_cnt == '0));

    assert_touch_translated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bar_done |-> (touch_cnt == '0));

    assert_safe_before_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bar_done) |-> $past(older_safe));

    assert_req_under_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_req |-> disp_stall);

    assert_retry_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bcast_req && bcast_ack && !bcast_ok) |=> bcast_req);

    assert_bad_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bad_form |=> !bad_form);

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_issue && !mem_done && (mem_cnt != {CNT_W{1'b1}})) |=> (mem_cnt != '0));
endmodule

bind membar_ctrl membar_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_issue  (mem_issue),
    .mem_done   (mem_done),
    .older_safe (older_safe),
    .bcast_ack  (bcast_ack),
    .bcast_ok   (bcast_ok),
    .bcast_req  (bcast_req),
    .disp_stall (disp_stall),
    .bar_done   (bar_done),
    .bad_form   (bad_form),
    .mem_cnt    (mem_cnt),
    .touch_cnt  (touch_cnt)
);

// File: tb/test_membar_ctrl.sv
`timescale 1ns/100ps
// Scoreboard bench: the driver pushes the cycle in which a completion is due,
// and a monitor pops it when bar_done appears.
module test_membar_ctrl;
    localparam int          OP_W   = 6;
    localparam logic [5:0]  BAR    = 6'd37;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disp_valid = 0, disp_rc = 0;
    logic [OP_W-1:0] disp_op = '0;
    logic mem_issue = 0, mem_done = 0, touch_issue = 0, touch_xlat_done = 0;
    logic older_safe = 1, bcast_en = 0, bcast_ack = 0, bcast_ok = 0;
    logic bcast_req, disp_stall, bar_done, bad_form;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int exp_q[$];
    bit finished = 0;

    always #2.5 clk = ~clk;

    membar_ctrl i_membar_ctrl (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_op(disp_op),
        .disp_rc(disp_rc), .mem_issue(mem_issue), .mem_done(mem_done),
        .touch_issue(touch_issue), .touch_xlat_done(touch_xlat_done),
        .older_safe(older_safe), .bcast_en(bcast_en), .bcast_ack(bcast_ack),
        .bcast_ok(bcast_ok), .bcast_req(bcast_req), .disp_stall(disp_stall),
        .bar_done(bar_done), .bad_form(bad_form)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_done();
        exp_q.push_back(cyc);
    endtask

    // Present one barrier (or other opcode) for one cycle
    task automatic dispatch(input logic [OP_W-1:0] op, input logic rc);
        disp_valid = 1; disp_op = op; disp_rc = rc;
        tick();
        disp_valid = 0; disp_rc = 0;
    endtask

    // Monitor: each completion must match the oldest expected cycle
    always @(negedge clk) begin
        if (rst_n && bar_done) begin
            if (exp_q.size() == 0) begin
                chk(0, "R9 unexpected bar_done", cyc, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(cyc == e, "R2 completion cycle", cyc, e);
            end
        end
    end

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            chk(0, "watchdog", cyc, 0);
            report();
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1;
        tick();
        // R10 reset state
        chk({disp_stall, bar_done, bcast_req, bad_form} == 4'b0, "R10 outputs after reset",
            {disp_stall, bar_done, bcast_req, bad_form}, 0);

        // R6 immediate completion
        dispatch(BAR, 0);
        expect_done();
        chk(bar_done == 1, "R6 done next cycle", bar_done, 1);
        tick();
        chk(disp_stall == 0, "R7 stall released", disp_stall, 0);
        chk(bar_done == 0, "R7 single pulse", bar_done, 0);

        // R9 other opcode ignored
        dispatch(6'd12, 0);
        chk(disp_stall == 0, "R9 no stall", disp_stall, 0);
        tick();
        chk(bar_done == 0, "R9 no completion", bar_done, 0);

        // R2 / R11 memory drain
        mem_issue = 1; tick(); tick(); tick(); mem_issue = 0;
        dispatch(BAR, 0);
        chk(disp_stall == 1, "R1 stall after accept", disp_stall, 1);
        mem_done = 1; tick(); tick();
        chk(disp_stall == 1, "R2 one still outstanding", disp_stall, 1);
        mem_issue = 1; tick(); mem_issue = 0;
        chk(disp_stall == 1, "R11 issue+done same cycle", disp_stall, 1);
        tick(); mem_done = 0;
        expect_done();
        chk(bar_done == 1, "R2 done after last completion", bar_done, 1);
        tick();

        // R3 touch waits for translation only
        touch_issue = 1; tick(); touch_issue = 0;
        dispatch(BAR, 0);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(disp_stall == 1 && bar_done == 0, "R3 held by translation", disp_stall, 1);
        end
        touch_xlat_done = 1; tick(); touch_xlat_done = 0;
        expect_done();
        chk(bar_done == 1, "R3 done after translation", bar_done, 1);
        tick();

        // R1 fault-point wait
        older_safe = 0;
        dispatch(BAR, 0);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk(disp_stall == 1, "R1 held by older_safe", disp_stall, 1);
        end
        older_safe = 1; tick();
        expect_done();
        tick();

        // R4 / R5 broadcast with retry
        bcast_en = 1;
        dispatch(BAR, 0);
        chk(bcast_req == 1 && disp_stall == 1, "R4 request raised", bcast_req, 1);
        tick();
        chk(bcast_req == 1 && bar_done == 0, "R4 waits for ack", bcast_req, 1);
        bcast_ack = 1; bcast_ok = 0; tick();
        chk(bcast_req == 1 && bar_done == 0, "R5 retry keeps request", bcast_req, 1);
        bcast_ok = 1; tick();
        bcast_ack = 0; bcast_ok = 0;
        expect_done();
        chk(bcast_req == 0, "R4 request dropped after ack", bcast_req, 0);
        bcast_en = 0;
        tick();

        // R8 invalid form
        dispatch(BAR, 1);
        expect_done();
        chk(bad_form == 1, "R8 flag raised", bad_form, 1);
        tick();
        chk(bad_form == 0, "R8 flag one cycle", bad_form, 0);
        tick();

        chk(exp_q.size() == 0, "R2 all completions seen", exp_q.size(), 0);
        finished = 1;
        report();
    end
endmodule